// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block holds a small set of virtual-to-physical page translations and searches all of them in parallel. Every entry is keyed by a process identifier together with a virtual page number. It carries four status bits: valid, writeable, referenced and modified. A lookup presents a process identifier, a 32-bit virtual address and a read/write flag. One cycle later the block reports one of three outcomes. A hit gives the 26-bit physical address. A miss means an outside page walker must supply the entry. A fault means a write tried to reach a page that is not writeable.

Translations come in through a refill port. A refill uses the lowest-numbered empty slot. When every slot is in use, it overwrites the slot chosen by a rotating pointer. Two flush inputs remove translations. One clears every entry, which suits a process switch. The other clears only the entries of one process, in a single cycle.

Top module: `xlat_buf`

## Requirements
- R1: Each lookup request gives exactly one registered result one cycle later: `rs_valid` is high and exactly one of `rs_hit`, `rs_miss`, `rs_fault` is high. Without a request, all four are low in the following cycle.
- R2: A lookup hits only when a valid entry matches both the process ID and the virtual page number (address bits 31:12). On a hit, `rs_paddr` is the entry's 14-bit frame number in bits 25:12, followed by the request's 12-bit page offset in bits 11:0.
- R3: When no valid entry matches, the result is a miss and `rs_paddr` is zero.
- R4: A write lookup that matches an entry whose writeable bit is clear gives a fault with `rs_hit` low and `rs_paddr` zero. It leaves that entry's referenced and modified bits unchanged. A read never faults.
- R5: A hit sets the entry's referenced bit. `rs_ref` reports the value that bit had before this access.
- R6: A write hit sets the entry's modified bit. `rs_mod` reports the value that bit had before this access.
- R7: A refill installs an entry with valid set, referenced and modified clear, and the given writeable bit. A lookup in the same cycle as a refill sees the contents from before the refill.
- R8: A refill goes to the lowest-indexed invalid entry. If all 8 entries are valid, it replaces the entry at the rotating pointer. The pointer is 0 after reset and advances by one, modulo 8, on each refill that replaces a valid entry.
- R9: `flush_all` invalidates every entry, so later lookups miss until new refills arrive.
- R10: A per-process flush invalidates, in one cycle, exactly the entries whose process ID equals `flush_pid`. Entries of other processes stay usable, with their status bits intact.
- R11: A refill in the same cycle as either flush is kept. The new entry is valid afterwards.
- R12: After reset all entries are invalid and no result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_pid | input | PID_W (8) | Process ID of the lookup |
| lk_vaddr | input | VA_W (32) | Virtual address of the lookup |
| lk_write | input | 1 | 1 = write access, 0 = read |
| fill_en | input | 1 | Install a translation |
| fill_pid | input | PID_W (8) | Process ID of the new entry |
| fill_vpn | input | VPN_W (20) | Virtual page number of the new entry |
| fill_pfn | input | PFN_W (14) | Physical frame number of the new entry |
| fill_wr | input | 1 | Writeable bit of the new entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | PID_W (8) | Process selected by `flush_pid_en` |
| rs_valid | output | 1 | A lookup result is present |
| rs_hit | output | 1 | Translation found |
| rs_miss | output | 1 | No translation present |
| rs_fault | output | 1 | Write to a non-writeable page |
| rs_paddr | output | PA_W (26) | Physical address on a hit, zero otherwise |
| rs_ref | output | 1 | Referenced bit before this hit |
| rs_mod | output | 1 | Modified bit before this hit |

## Verification
The assertions assume that a refill never installs a process/page pair that is already present in a valid entry. Under that assumption at most one entry can match a lookup. The bench keeps to this: its reference model drops any random refill whose key is already held. The assertions also assume that inputs are steady around each rising edge, and the bench meets this by driving on the falling edge. Random lookups draw from 4 processes and 16 pages, so hits, faults, evictions and flushes that meet in the same cycle all occur often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Per-entry status bits
  typedef struct packed {
    logic valid;
    logic wr;
    logic ref_b;
    logic mod_b;
  } stat_t;

  // Outcome of one lookup
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_FAULT = 2'd3
  } res_e;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_arr,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_arr,
  input  logic [PID_W-1:0]              key_pid,
  input  logic [VPN_W-1:0]              key_vpn,
  output logic [ENTRIES-1:0]            hit_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid_vec[i] && (pid_arr[i] == key_pid) && (vpn_arr[i] == key_vpn);
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   vic_idx,
  output logic               all_full
);

  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign all_full = &valid_vec;
  assign vic_idx  = all_full ? rr_ptr : free_idx;

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 14,
  parameter int PID_W   = 8,
  parameter int ENTRIES = 8,
  parameter int VPN_W   = VA_W - OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_req,
  input  logic [PID_W-1:0]       lk_pid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic                   lk_write,
  input  logic                   fill_en,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic                   fill_wr,
  input  logic                   flush_all,
  input  logic                   flush_pid_en,
  input  logic [PID_W-1:0]       flush_pid,
  output logic                   rs_valid,
  output logic                   rs_hit,
  output logic                   rs_miss,
  output logic                   rs_fault,
  output logic [PFN_W+OFF_W-1:0] rs_paddr,
  output logic                   rs_ref,
  output logic                   rs_mod
);
  import xlat_pkg::*;

  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Entry storage
  stat_t [ENTRIES-1:0]            st_q, st_d;
  logic  [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic  [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic  [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic  [IDX_W-1:0]              ptr_q, ptr_d;

  logic [ENTRIES-1:0] valid_vec, hit_vec;
  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx, vic_idx;
  logic               all_full;
  stat_t              sel_st;
  res_e               kind;

  // Result registers
  logic            rv_d, rh_d, rm_d, rf_d, rr_d, rmod_d;
  logic [PA_W-1:0] pa_d;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
    assign valid_vec[i] = st_q[i].valid;
  end

  xlat_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_match (
    .valid_vec (valid_vec),
    .pid_arr   (pid_q),
    .vpn_arr   (vpn_q),
    .key_pid   (lk_pid),
    .key_vpn   (lk_vpn),
    .hit_vec   (hit_vec)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_vec (valid_vec),
    .rr_ptr    (ptr_q),
    .vic_idx   (vic_idx),
    .all_full  (all_full)
  );

  // Encode the (at most one) matching entry
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hit_vec;
  assign sel_st  = st_q[hit_idx];

  always_comb begin
    if (!lk_req)                       kind = RES_NONE;
    else if (!hit_any)                 kind = RES_MISS;
    else if (lk_write && !sel_st.wr)   kind = RES_FAULT;
    else                               kind = RES_HIT;
  end

  // Next state of entry status and pointer: access update, then flush, then refill
  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (kind == RES_HIT) begin
      st_d[hit_idx].ref_b = 1'b1;
      if (lk_write) st_d[hit_idx].mod_b = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (flush_all || (flush_pid_en && (pid_q[i] == flush_pid))) st_d[i].valid = 1'b0;
    end
    if (fill_en) begin
      st_d[vic_idx] = '{valid: 1'b1, wr: fill_wr, ref_b: 1'b0, mod_b: 1'b0};
      if (all_full) begin
        if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
        else                              ptr_d = ptr_q + 1'b1;
      end
    end
  end

  // Next result
  always_comb begin
    rv_d   = lk_req;
    rh_d   = (kind == RES_HIT);
    rm_d   = (kind == RES_MISS);
    rf_d   = (kind == RES_FAULT);
    pa_d   = rh_d ? {pfn_q[hit_idx], lk_off} : '0;
    rr_d   = rh_d & sel_st.ref_b;
    rmod_d = rh_d & sel_st.mod_b;
  end

  // Status and control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q     <= '0;
      ptr_q    <= '0;
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_paddr <= '0;
      rs_ref   <= 1'b0;
      rs_mod   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      rs_valid <= rv_d;
      rs_hit   <= rh_d;
      rs_miss  <= rm_d;
      rs_fault <= rf_d;
      if (lk_req) begin
        rs_paddr <= pa_d;
        rs_ref   <= rr_d;
        rs_mod   <= rmod_d;
      end
    end
  end

  // Translation payload, loaded only on refill
  always_ff @(posedge clk) begin
    if (fill_en) begin
      pid_q[vic_idx] <= fill_pid;
      vpn_q[vic_idx] <= fill_vpn;
      pfn_q[vic_idx] <= fill_pfn;
    end
  end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic            lk_write,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            fill_en,
  input logic            flush_all,
  input logic            rs_valid,
  input logic            rs_hit,
  input logic            rs_miss,
  input logic            rs_fault,
  input logic [PA_W-1:0] rs_paddr
);

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rs_valid && !rs_hit && !rs_miss && !rs_fault));

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!rs_hit || (rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))));

  assert_nonhit_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_paddr == '0));

  assert_read_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_write) |=> !rs_fault);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) ##1 lk_req |=> !rs_hit);

endmodule

bind xlat_buf xlat_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .lk_req    (lk_req),
  .lk_write  (lk_write),
  .lk_vaddr  (lk_vaddr),
  .fill_en   (fill_en),
  .flush_all (flush_all),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_miss   (rs_miss),
  .rs_fault  (rs_fault),
  .rs_paddr  (rs_paddr)
);

// File: tb/tb_xlat_buf.sv
`timescale 1ns/1ps
module tb_xlat_buf;
  localparam int N = 8;

  logic        clk, rst_n;
  logic        lk_req, lk_write, fill_en, fill_wr, flush_all, flush_pid_en;
  logic [7:0]  lk_pid, fill_pid, flush_pid;
  logic [31:0] lk_vaddr;
  logic [19:0] fill_vpn;
  logic [13:0] fill_pfn;
  logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_ref, rs_mod;
  logic [25:0] rs_paddr;

  int vectors = 0;
  int errors  = 0;

  // Reference model state
  bit m_v[N], m_w[N], m_r[N], m_m[N];
  int m_pid[N], m_vpn[N], m_pfn[N];
  int m_ptr;

  xlat_buf dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_pid(lk_pid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .fill_en(fill_en), .fill_pid(fill_pid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_wr(fill_wr), .flush_all(flush_all),
    .flush_pid_en(flush_pid_en), .flush_pid(flush_pid), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_paddr(rs_paddr),
    .rs_ref(rs_ref), .rs_mod(rs_mod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_up();
  end

  function automatic bit key_present(int pid, int vpn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pid[i] == pid && m_vpn[i] == vpn) return 1'b1;
    return 1'b0;
  endfunction

  // One cycle: drive, predict, update model, compare
  task automatic step(string tag, bit req, int pid, int vpn, int off, bit wr,
                      bit fill, int fpid, int fvpn, int fpfn, bit fw,
                      bit fa, bit fpe, int fp);
    int idx, vic;
    bit full, eh, em, ef, er, emo;
    int epa;
    @(negedge clk);
    lk_req = req; lk_pid = 8'(pid); lk_vaddr = {20'(vpn), 12'(off)}; lk_write = wr;
    fill_en = fill; fill_pid = 8'(fpid); fill_vpn = 20'(fvpn); fill_pfn = 14'(fpfn);
    fill_wr = fw; flush_all = fa; flush_pid_en = fpe; flush_pid = 8'(fp);
    idx = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pid[i] == pid && m_vpn[i] == vpn) idx = i;
    eh = 0; em = 0; ef = 0; er = 0; emo = 0; epa = 0;
    if (req) begin
      if (idx < 0) em = 1;
      else if (wr && !m_w[idx]) ef = 1;
      else begin
        eh = 1; epa = m_pfn[idx] * 4096 + off; er = m_r[idx]; emo = m_m[idx];
      end
    end
    vic = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
    full = (vic < 0);
    if (full) vic = m_ptr;
    if (eh) begin
      m_r[idx] = 1;
      if (wr) m_m[idx] = 1;
    end
    for (int i = 0; i < N; i++)
      if (fa || (fpe && m_pid[i] == fp)) m_v[i] = 0;
    if (fill) begin
      m_v[vic] = 1; m_w[vic] = fw; m_r[vic] = 0; m_m[vic] = 0;
      m_pid[vic] = fpid; m_vpn[vic] = fvpn; m_pfn[vic] = fpfn;
      if (full) m_ptr = (m_ptr + 1) % N;
    end
    @(posedge clk);
    #1;
    vectors++;
    if (req) begin
      if (rs_valid !== 1'b1 || rs_hit !== eh || rs_miss !== em || rs_fault !== ef ||
          rs_paddr !== 26'(epa) || (eh && (rs_ref !== er || rs_mod !== emo))) begin
        errors++;
        $display("FAIL %s: v=%0b h=%0b m=%0b f=%0b pa=%h ref=%0b mod=%0b expected v=1 h=%0b m=%0b f=%0b pa=%h ref=%0b mod=%0b",
                 tag, rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr, rs_ref, rs_mod,
                 eh, em, ef, 26'(epa), er, emo);
      end
    end else if (rs_valid !== 1'b0 || rs_hit !== 1'b0 || rs_miss !== 1'b0 || rs_fault !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: v=%0b h=%0b m=%0b f=%0b expected all 0",
               tag, rs_valid, rs_hit, rs_miss, rs_fault);
    end
  endtask

  task automatic look(string tag, int pid, int vpn, int off, bit wr);
    step(tag, 1, pid, vpn, off, wr, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string tag, int pid, int vpn, int pfn, bit w);
    step(tag, 0, 0, 0, 0, 0, 1, pid, vpn, pfn, w, 0, 0, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    lk_req = 0; lk_pid = 0; lk_vaddr = 0; lk_write = 0; fill_en = 0; fill_pid = 0;
    fill_vpn = 0; fill_pfn = 0; fill_wr = 0; flush_all = 0; flush_pid_en = 0; flush_pid = 0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_r[i] = 0; m_m[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
    end
    m_ptr = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    vectors++;
    if (rs_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12: rs_valid=%0b expected 0", rs_valid);
    end

    // R12 / R3: empty after reset
    look("R12", 1, 5, 12'h123, 0);
    // R7: lookup in the refill cycle sees old contents
    step("R7", 1, 1, 5, 12'h010, 0, 1, 1, 5, 14'h2a5, 1, 0, 0, 0);
    // R2 / R5: hits, referenced bit first clear then set
    look("R5", 1, 5, 12'hfff, 0);
    look("R2", 1, 5, 12'h000, 0);
    look("R2", 2, 5, 12'h000, 0);
    // R6: write hit sets modified
    look("R6", 1, 5, 12'h044, 1);
    look("R6", 1, 5, 12'h044, 0);
    // R4: write to read-only page
    fill("R7", 3, 7, 14'h3fff, 0);
    look("R4", 3, 7, 12'h001, 1);
    look("R4", 3, 7, 12'h002, 0);
    look("R4", 3, 7, 12'h003, 1);
    // R8: fill the rest, then evict by pointer
    for (int v = 0; v < 6; v++) fill("R8", 4, v, 100 + v, 1);
    fill("R8", 4, 20, 14'h111, 1);
    look("R8", 1, 5, 0, 0);
    fill("R8", 4, 21, 14'h222, 1);
    look("R8", 3, 7, 0, 0);
    look("R8", 4, 20, 12'habc, 0);
    // R10: per-process flush
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4);
    look("R10", 4, 21, 0, 0);
    look("R10", 4, 2, 0, 0);
    // R8: refill now uses lowest invalid slot
    fill("R8", 5, 9, 14'h0999, 1);
    look("R8", 5, 9, 12'h321, 0);
    // R11: refill together with per-process flush of its own process
    step("R11", 0, 0, 0, 0, 0, 1, 5, 10, 14'h0aaa, 1, 0, 1, 5);
    look("R11", 5, 10, 12'h1, 0);
    look("R10", 5, 9, 12'h1, 0);
    // R9 / R11: full flush with simultaneous refill
    step("R11", 0, 0, 0, 0, 0, 1, 6, 1, 14'h0bbb, 1, 1, 0, 0);
    look("R9", 4, 0, 0, 0);
    look("R11", 6, 1, 12'h7, 1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      bit req, wr, fl, fw, fa, fpe;
      int pid, vpn, off, fpid, fvpn, fpfn, fp;
      req  = ($urandom % 10) < 7;
      pid  = $urandom % 4;
      vpn  = $urandom % 16;
      off  = $urandom % 4096;
      wr   = ($urandom % 10) < 3;
      fl   = ($urandom % 4) == 0;
      fpid = $urandom % 4;
      fvpn = $urandom % 16;
      fpfn = $urandom % 16384;
      fw   = ($urandom % 3) != 0;
      fa   = ($urandom % 100) == 0;
      fpe  = ($urandom % 100) < 3;
      fp   = $urandom % 4;
      if (fl && key_present(fpid, fvpn)) fl = 0;
      step("R1-R11 random", req, pid, vpn, off, wr, fl, fpid, fvpn, fpfn, fw, fa, fpe, fp);
    end
    finish_up();
  end
endmodule